// File: doc/BRIEF.md
# Dual-target interrupt routing controller

This block gathers up to 32 interrupt sources and presents them to two processors. Every source feeds two separate pending-flag sets, one per processor. Each processor therefore sees and acknowledges a source on its own. Software clears a pending bit by writing a one to it. Each processor's interrupt line is raised when a pending bit in its own set meets an enable bit in its own mask. The second processor also has an extra enable mask that drives a fast-interrupt line, separate from its normal line.

Software reaches the registers over a simple 32-bit word bus with a write strobe, a read strobe and a byte address. Read data is registered. Bus words are big-endian, so the bytes of every word are swapped between the bus and the internal bit numbering. Source `n` always maps to register bit `n`.

Top module: `irq_router`

## Requirements
- R1: After synchronous reset every register reads zero, `bus_rdata` is zero and `cpu0_irq`, `cpu1_irq` and `cpu1_fiq` are low.
- R2: At the first clock edge where `src_in[n]` is high after being low at the previous edge, bit `n` is set in both pending sets. A source held high sets its bits only once, so a cleared bit stays clear while the level persists.
- R3: A write to the pending register of one processor clears each bit written as one and leaves bits written as zero unchanged. It never alters the other processor's pending set.
- R4: When a source edge and a write-one-clear reach the same pending bit at the same edge, the bit ends up set.
- R5: The three mask registers store what is written and read it back unchanged.
- R6: `cpu0_irq` is high one cycle after any bit is both pending for processor 0 and enabled in mask 0, and low one cycle after no such bit exists.
- R7: `cpu1_irq` follows the same rule using processor 1's pending set and mask 1.
- R8: `cpu1_fiq` follows the same rule using processor 1's pending set and the fast mask, regardless of mask 1.
- R9: Offsets that hold no register read as zero, and writes to them change no register. Only the low address bits above bit 1 are decoded.
- R10: Byte offsets are 0x30 for pending 0, 0x34 for mask 0, 0x38 for pending 1, 0x3C for mask 1 and 0x40 for the fast mask. With the default big-endian setting, bus byte lane `bus_wdata[7:0]` / `bus_rdata[7:0]` carries register bits 31:24. For example, bus word 0x00000001 is register bit 24.
- R11: Read data for a read strobe sampled at an edge appears on `bus_rdata` after that edge and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_addr | input | AW (8) | Byte offset of the access |
| bus_wdata | input | 32 | Write data, big-endian lanes |
| bus_rdata | output | 32 | Registered read data, big-endian lanes |
| src_in | input | N (32) | Interrupt source inputs, rising edge sets pending |
| cpu0_irq | output | 1 | Processor 0 interrupt, registered |
| cpu1_irq | output | 1 | Processor 1 normal interrupt, registered |
| cpu1_fiq | output | 1 | Processor 1 fast interrupt, registered |

## Verification
A source edge and a software acknowledge of the same pending bit can land on one clock edge. The bench raises a source and writes a one to that bit of processor 0's pending register at the same clock edge. It then reads the register back and expects the bit still set, and it checks that processor 1's copy is also set. A second collision case clears a different bit at that same edge. The clear must take effect while the new edge still sets its own bit.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int unsigned BUS_W = 32;

  localparam int unsigned OFS_PEND0 = 'h30;
  localparam int unsigned OFS_MASK0 = 'h34;
  localparam int unsigned OFS_PEND1 = 'h38;
  localparam int unsigned OFS_MASK1 = 'h3C;
  localparam int unsigned OFS_FAST1 = 'h40;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND0,
    SEL_MASK0,
    SEL_PEND1,
    SEL_MASK1,
    SEL_FAST1
  } reg_sel_t;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src,
  output logic [N-1:0] src_q,
  output logic [N-1:0] rise
);

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src;
  end

  assign rise = src & ~src_q;

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_bits,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] flags
);

  logic [N-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_bits : '0;

  // a fresh edge overrides a simultaneous acknowledge
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr_eff) | set_bits;
  end

endmodule

// File: rtl/irq_bus_regs.sv
module irq_bus_regs
  import irq_router_pkg::*;
#(
  parameter int N          = 32,
  parameter int AW         = 8,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic [AW-1:0]    addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  input  logic [N-1:0]     pend0,
  input  logic [N-1:0]     pend1,
  output logic             clr0_we,
  output logic             clr1_we,
  output logic [N-1:0]     clr_bits,
  output logic [N-1:0]     mask0,
  output logic [N-1:0]     mask1,
  output logic [N-1:0]     fast1
);

  localparam int WA = AW - 2;

  logic [BUS_W-1:0] wd_int;
  logic [BUS_W-1:0] rd_int;
  logic [BUS_W-1:0] rd_bus;
  logic [WA-1:0]    waddr;
  reg_sel_t         sel;

  generate
    if (BIG_ENDIAN) begin : g_swap
      assign wd_int = {wdata[7:0], wdata[15:8], wdata[23:16], wdata[31:24]};
      assign rd_bus = {rd_int[7:0], rd_int[15:8], rd_int[23:16], rd_int[31:24]};
    end else begin : g_flat
      assign wd_int = wdata;
      assign rd_bus = rd_int;
    end
  endgenerate

  assign waddr = addr[AW-1:2];

  always_comb begin
    sel = SEL_NONE;
    if      (waddr == WA'(OFS_PEND0 >> 2)) sel = SEL_PEND0;
    else if (waddr == WA'(OFS_MASK0 >> 2)) sel = SEL_MASK0;
    else if (waddr == WA'(OFS_PEND1 >> 2)) sel = SEL_PEND1;
    else if (waddr == WA'(OFS_MASK1 >> 2)) sel = SEL_MASK1;
    else if (waddr == WA'(OFS_FAST1 >> 2)) sel = SEL_FAST1;
  end

  assign clr_bits = wd_int[N-1:0];
  assign clr0_we  = wr && (sel == SEL_PEND0);
  assign clr1_we  = wr && (sel == SEL_PEND1);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask0 <= '0;
      mask1 <= '0;
      fast1 <= '0;
    end else if (wr) begin
      case (sel)
        SEL_MASK0: mask0 <= wd_int[N-1:0];
        SEL_MASK1: mask1 <= wd_int[N-1:0];
        SEL_FAST1: fast1 <= wd_int[N-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_PEND0: rd_int = BUS_W'(pend0);
      SEL_MASK0: rd_int = BUS_W'(mask0);
      SEL_PEND1: rd_int = BUS_W'(pend1);
      SEL_MASK1: rd_int = BUS_W'(mask1);
      SEL_FAST1: rd_int = BUS_W'(fast1);
      default:   rd_int = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_bus;
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int N          = 32,
  parameter int AW         = 8,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [N-1:0]     src_in,
  output logic             cpu0_irq,
  output logic             cpu1_irq,
  output logic             cpu1_fiq
);

  localparam int NCPU = 2;

  logic [N-1:0] src_q;
  logic [N-1:0] rise;
  logic [N-1:0] clr_bits;
  logic [N-1:0] mask0, mask1, fast1;
  logic [N-1:0] pend [NCPU];
  logic [NCPU-1:0] clr_we;

  irq_edge_detect #(.N(N)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .src   (src_in),
    .src_q (src_q),
    .rise  (rise)
  );

  generate
    for (genvar g = 0; g < NCPU; g++) begin : g_bank
      irq_flag_bank #(.N(N)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .set_bits (rise),
        .clr_we   (clr_we[g]),
        .clr_bits (clr_bits),
        .flags    (pend[g])
      );
    end
  endgenerate

  irq_bus_regs #(.N(N), .AW(AW), .BIG_ENDIAN(BIG_ENDIAN)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .pend0    (pend[0]),
    .pend1    (pend[1]),
    .clr0_we  (clr_we[0]),
    .clr1_we  (clr_we[1]),
    .clr_bits (clr_bits),
    .mask0    (mask0),
    .mask1    (mask1),
    .fast1    (fast1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu0_irq <= 1'b0;
      cpu1_irq <= 1'b0;
      cpu1_fiq <= 1'b0;
    end else begin
      cpu0_irq <= |(pend[0] & mask0);
      cpu1_irq <= |(pend[1] & mask1);
      cpu1_fiq <= |(pend[1] & fast1);
    end
  end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] src_in,
  input logic [N-1:0] src_q,
  input logic [N-1:0] pend0,
  input logic [N-1:0] pend1,
  input logic [N-1:0] mask0,
  input logic [N-1:0] mask1,
  input logic [N-1:0] fast1,
  input logic         cpu0_irq,
  input logic         cpu1_irq,
  input logic         cpu1_fiq
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!cpu0_irq && !cpu1_irq && !cpu1_fiq && pend0 == '0 && pend1 == '0));

  // R2
  edge_sets_both_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((($past(src_in & ~src_q)) & ~(pend0 & pend1)) == '0));

  // R6
  cpu0_route_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (cpu0_irq == $past(|(pend0 & mask0))));

  // R7
  cpu1_route_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (cpu1_irq == $past(|(pend1 & mask1))));

  // R8
  cpu1_fast_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (cpu1_fiq == $past(|(pend1 & fast1))));

endmodule

bind irq_router irq_router_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .src_in   (src_in),
  .src_q    (src_q),
  .pend0    (pend[0]),
  .pend1    (pend[1]),
  .mask0    (mask0),
  .mask1    (mask1),
  .fast1    (fast1),
  .cpu0_irq (cpu0_irq),
  .cpu1_irq (cpu1_irq),
  .cpu1_fiq (cpu1_fiq)
);

// File: tb/irq_router_test.sv
module irq_router_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src_in = '0;
  logic        cpu0_irq, cpu1_irq, cpu1_fiq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model of register state
  logic [31:0] m_p0 = '0, m_p1 = '0, m_k0 = '0, m_k1 = '0, m_f1 = '0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } rd_item_t;
  rd_item_t exp_q [$];
  logic rd_q = 1'b0;

  always #2 clk = ~clk;

  irq_router uut (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_in    (src_in),
    .cpu0_irq  (cpu0_irq),
    .cpu1_irq  (cpu1_irq),
    .cpu1_fiq  (cpu1_fiq)
  );

  function automatic logic [31:0] sw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data the cycle after a read strobe
  always @(posedge clk) rd_q <= bus_rd;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) check("R11 unexpected read", 32'h1, 32'h0);
      else begin
        rd_item_t it;
        it = exp_q.pop_front();
        check(it.tag, bus_rdata, it.val);
      end
    end
  end

  task automatic bus_read(input logic [7:0] a, input logic [31:0] exp_bus, input string tag);
    rd_item_t it;
    @(negedge clk);
    bus_rd   = 1'b1;
    bus_addr = a;
    it.val = exp_bus;
    it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] reg_val);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = sw(reg_val);
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      8'h30: m_p0 &= ~reg_val;
      8'h34: m_k0 = reg_val;
      8'h38: m_p1 &= ~reg_val;
      8'h3C: m_k1 = reg_val;
      8'h40: m_f1 = reg_val;
      default: ;
    endcase
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    src_in[n] = 1'b1;
    @(negedge clk);
    src_in[n] = 1'b0;
    m_p0[n] = 1'b1;
    m_p1[n] = 1'b1;
  endtask

  task automatic check_outs(input string tag);
    @(negedge clk);
    check({tag, " cpu0_irq"}, 32'(cpu0_irq), 32'(|(m_p0 & m_k0)));
    check({tag, " cpu1_irq"}, 32'(cpu1_irq), 32'(|(m_p1 & m_k1)));
    check({tag, " cpu1_fiq"}, 32'(cpu1_fiq), 32'(|(m_p1 & m_f1)));
  endtask

  task automatic read_all(input string tag);
    bus_read(8'h30, sw(m_p0), {tag, " pend0"});
    bus_read(8'h34, sw(m_k0), {tag, " mask0"});
    bus_read(8'h38, sw(m_p1), {tag, " pend1"});
    bus_read(8'h3C, sw(m_k1), {tag, " mask1"});
    bus_read(8'h40, sw(m_f1), {tag, " fast1"});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 outputs", {29'h0, cpu0_irq, cpu1_irq, cpu1_fiq}, 32'h0);
    rst = 1'b0;
    read_all("R1");

    // R5 and R10: mask read-back, lane order
    bus_write(8'h34, 32'h0000_0008);
    bus_read(8'h34, 32'h0800_0000, "R10 mask0 lane order");
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h3C; bus_wdata = 32'h0000_0001;
    @(negedge clk);
    bus_wr = 1'b0;
    m_k1 = 32'h0100_0000;
    bus_read(8'h3C, 32'h0000_0001, "R5 mask1 readback");

    // R2, R6: pulse source 3 sets both sets, routes to cpu0 only
    pulse(3);
    check_outs("R6 after src3");
    read_all("R2 after src3");

    // R10, R7: source 24 reaches cpu1 through bus lane bit 0
    pulse(24);
    check_outs("R7 src24");

    // R3: acknowledge bit 3 on cpu0 only, zeros elsewhere keep bit 24
    bus_write(8'h30, 32'h0000_0008);
    check_outs("R3 ack cpu0");
    read_all("R3 after ack");

    // R8: fast mask independent of mask1
    bus_write(8'h3C, 32'h0);
    bus_write(8'h40, 32'h0000_0008);
    check_outs("R8 fast only");
    bus_write(8'h40, 32'h0);
    check_outs("R8 fast off");
    bus_write(8'h3C, 32'h0000_0008);
    check_outs("R7 mask1 bit3");

    // R2: held level sets once
    @(negedge clk);
    src_in[7] = 1'b1;
    m_p0[7] = 1'b1; m_p1[7] = 1'b1;
    bus_write(8'h30, 32'h0000_0080);
    repeat (3) @(negedge clk);
    bus_read(8'h30, sw(m_p0), "R2 held level no re-set");

    // R4: edge and clear on same bit; another bit cleared at the same edge
    bus_write(8'h34, 32'h0000_0200);
    pulse(12);
    @(negedge clk);
    src_in[9] = 1'b1;
    bus_wr = 1'b1; bus_addr = 8'h30; bus_wdata = sw(32'h0000_1200);
    @(negedge clk);
    bus_wr = 1'b0;
    src_in[9] = 1'b0;
    m_p0 = (m_p0 & ~32'h0000_1200) | 32'h0000_0200;
    m_p1 = m_p1 | 32'h0000_0200;
    check_outs("R4 set wins");
    bus_read(8'h30, sw(m_p0), "R4 pend0 after collision");
    bus_read(8'h38, sw(m_p1), "R4 pend1 after collision");

    // R9: unused offsets
    bus_write(8'h44, 32'hFFFF_FFFF);
    bus_write(8'h5C, 32'hFFFF_FFFF);
    bus_read(8'h44, 32'h0, "R9 unused 0x44 reads zero");
    bus_read(8'h58, 32'h0, "R9 unused 0x58 reads zero");
    read_all("R9 regs untouched");
    check_outs("R9 outputs untouched");

    // R11: read data holds without a new read
    bus_read(8'h34, sw(m_k0), "R11 read data");
    repeat (3) @(negedge clk);
    check("R11 rdata holds", bus_rdata, sw(m_k0));

    src_in[7] = 1'b0;
    repeat (4) @(negedge clk);
    check("R11 queue drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule